// File: doc/BRIEF.md
# Fractional-Rate Master Counter

This block keeps a wide free-running count that advances at a fixed nominal rate, even though the clock that drives it runs at one of several system frequencies. On every system clock the block adds a programmable increment to a small fractional accumulator. When the accumulator reaches a programmable modulus, the modulus is subtracted and the count steps by one. Over time the count therefore moves at clock × increment / modulus. For example, a 38.4 MHz clock with 4/25 yields 6.144 MHz, and a 12 MHz clock with 64/125 yields the same rate.

Software sets the ratio through a 32-byte register window and reads the count there as two bus words. The ratio fields are 12 bits wide. Software is expected to change them with a read-modify-write that keeps bits 31:12 intact. Any ratio write restarts the fractional phase and leaves the count itself untouched. Reading the low count word captures the upper part of the count in the same cycle, so a following read of the upper word pairs with it even across a carry.

Top module: `frc_master_counter`

## Requirements
- R1: A synchronous active-high reset sets the count to the `RESET_COUNT` parameter (zero by default), clears the accumulator and loads increment 4 and modulus 25. After reset the words at offsets 0x10 and 0x14 read 0x00000004 and 0x00000019.
- R2: After a ratio write, with 0 < increment ≤ modulus, the count n clocks later equals the count at that write plus floor(n × increment / modulus).
- R3: The count changes by at most one per clock, and only ever upward by one.
- R4: On the clock edge that takes a write to offset 0x10 or 0x14, the accumulator is cleared and the count keeps its value.
- R5: While the increment is zero or the modulus is zero, the count holds its value.
- R6: Offset 0x10 bits 11:0 hold the increment and offset 0x14 bits 11:0 hold the modulus. Bits 31:12 of both words store and read back the value last written to them, and they have no effect on the rate.
- R7: Offset 0x00 reads the live count bits 31:0. A read (select without write) of offset 0x00 captures count bits 63:32 on that edge, and offset 0x04 returns the captured value.
- R8: Writes to offsets 0x00, 0x04 and any offset outside 0x10/0x14 change neither the count nor the ratio. Reads of unmapped offsets return zero.
- R9: With the reset ratio 4/25 the count rises by exactly 4 every 25 clocks. With the ratio 75/244 it rises by exactly 75 every 244 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset within the register window |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Read data for the addressed offset, combinational |
| count_o | output | CNT_W (64) | Live count value |
| step_o | output | 1 | High in a cycle whose closing edge increments the count |

## Verification
The hardest case to reach is a coherent two-word read while the low word rolls over. At nominal rates a 32-bit roll takes minutes, and nothing in the register window can preset the count. The bench therefore builds the block with `RESET_COUNT` set 128 counts below a roll. It counts edges from reset release and uses the 4/25 schedule to place the low-word read in the exact cycle before the rolling edge. The upper-word read in the next cycle must then return the pre-roll value. The ratio runs start from arbitrary accumulator phases, so every per-cycle expected value also tests that a ratio write resets the phase.

// File: rtl/frc_pkg.sv
package frc_pkg;

   localparam int WIN_ADDR_W = 5;

   localparam logic [WIN_ADDR_W-1:0] OFS_CNT_LO = 5'h00;
   localparam logic [WIN_ADDR_W-1:0] OFS_CNT_HI = 5'h04;
   localparam logic [WIN_ADDR_W-1:0] OFS_INCR   = 5'h10;
   localparam logic [WIN_ADDR_W-1:0] OFS_MOD    = 5'h14;

   typedef enum logic [2:0] {
      REG_CNT_LO,
      REG_CNT_HI,
      REG_INCR,
      REG_MOD,
      REG_NONE
   } frc_reg_e;

   function automatic frc_reg_e frc_decode(input logic [WIN_ADDR_W-1:0] ofs);
      frc_reg_e r;
      case (ofs)
         OFS_CNT_LO: r = REG_CNT_LO;
         OFS_CNT_HI: r = REG_CNT_HI;
         OFS_INCR:   r = REG_INCR;
         OFS_MOD:    r = REG_MOD;
         default:    r = REG_NONE;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/frc_ratio_regs.sv
module frc_ratio_regs #(
   parameter int BUS_W     = 32,
   parameter int FRAC_W    = 12,
   parameter int RESET_NUM = 4,
   parameter int RESET_DEN = 25
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_incr,
   input  logic              wr_mod,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  incr_word,
   output logic [BUS_W-1:0]  mod_word,
   output logic [FRAC_W-1:0] incr,
   output logic [FRAC_W-1:0] modulus
);

   localparam int NREG = 2;

   if (FRAC_W > BUS_W) begin : g_bad_frac
      $error("frc_ratio_regs: FRAC_W must fit in a bus word");
   end
   if (RESET_NUM >= (1 << FRAC_W) || RESET_DEN >= (1 << FRAC_W)) begin : g_bad_rst
      $error("frc_ratio_regs: reset ratio does not fit FRAC_W");
   end
   if (RESET_NUM > RESET_DEN) begin : g_bad_ratio
      $error("frc_ratio_regs: reset increment exceeds reset modulus");
   end

   logic [BUS_W-1:0] word_q [NREG];
   logic [NREG-1:0]  wr_vec;

   assign wr_vec = {wr_mod, wr_incr};

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [BUS_W-1:0] RV = (g == 0) ? BUS_W'(RESET_NUM) : BUS_W'(RESET_DEN);
      always_ff @(posedge clk) begin
         if (rst) begin
            word_q[g] <= RV;
         end else if (wr_vec[g]) begin
            word_q[g] <= wdata;
         end
      end
   end

   assign incr_word = word_q[0];
   assign mod_word  = word_q[1];
   assign incr      = word_q[0][FRAC_W-1:0];
   assign modulus   = word_q[1][FRAC_W-1:0];

endmodule

// File: rtl/frc_accum.sv
module frc_accum #(
   parameter int FRAC_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic [FRAC_W-1:0] incr,
   input  logic [FRAC_W-1:0] modulus,
   output logic              step
);

   localparam int SUM_W = FRAC_W + 1;

   if (FRAC_W < 2) begin : g_bad_w
      $error("frc_accum: FRAC_W too small");
   end

   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W-1:0] acc_d;
   logic [SUM_W-1:0]  sum;
   logic              mod_zero;
   logic              hit;

   always_comb begin
      sum      = {1'b0, acc_q} + {1'b0, incr};
      mod_zero = (modulus == '0);
      hit      = !mod_zero && (sum >= {1'b0, modulus});
      if (clr || mod_zero) begin
         acc_d = '0;
      end else if (hit) begin
         acc_d = FRAC_W'(sum - {1'b0, modulus});
      end else begin
         acc_d = sum[FRAC_W-1:0];
      end
   end

   assign step = hit && !clr;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
      end else begin
         acc_q <= acc_d;
      end
   end

   // The fractional phase stays below the modulus while the ratio is proper.
   assert_acc_below_mod_R2: assert property (@(posedge clk) disable iff (rst)
      (modulus != '0 && incr <= modulus) |-> (acc_q < modulus))
      else $error("accumulator reached modulus");

   // A ratio write restarts the phase from zero.
   assert_clr_restarts_R4: assert property (@(posedge clk) disable iff (rst)
      clr |=> (acc_q == '0))
      else $error("accumulator not cleared by ratio write");

endmodule

// File: rtl/frc_count.sv
module frc_count #(
   parameter int                 CNT_W       = 64,
   parameter int                 BUS_W       = 32,
   parameter logic [CNT_W-1:0]   RESET_COUNT = '0,
   parameter bit                 SNAP_HI     = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    step,
   input  logic                    latch_hi,
   output logic [CNT_W-1:0]        count,
   output logic [CNT_W-BUS_W-1:0]  hi_word
);

   localparam int HI_W = CNT_W - BUS_W;

   if (CNT_W <= BUS_W || CNT_W > 2 * BUS_W) begin : g_bad_w
      $error("frc_count: CNT_W must lie in (BUS_W, 2*BUS_W]");
   end

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         count_q <= RESET_COUNT;
      end else if (step) begin
         count_q <= count_q + CNT_W'(1);
      end
   end

   assign count = count_q;

   if (SNAP_HI) begin : g_snap
      logic [HI_W-1:0] hi_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            hi_q <= RESET_COUNT[CNT_W-1:BUS_W];
         end else if (latch_hi) begin
            hi_q <= count_q[CNT_W-1:BUS_W];
         end
      end
      assign hi_word = hi_q;

      assert_hi_pairs_lo_R7: assert property (@(posedge clk) disable iff (rst)
         latch_hi |=> (hi_q == $past(count_q[CNT_W-1:BUS_W])))
         else $error("upper word not captured with low word");
   end else begin : g_live
      assign hi_word = count_q[CNT_W-1:BUS_W];
   end

   assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (count_q == $past(count_q) || count_q == $past(count_q) + CNT_W'(1)))
      else $error("count moved by more than one");

endmodule

// File: rtl/frc_master_counter.sv
module frc_master_counter #(
   parameter int               BUS_W       = 32,
   parameter int               FRAC_W      = 12,
   parameter int               CNT_W       = 64,
   parameter int               RESET_NUM   = 4,
   parameter int               RESET_DEN   = 25,
   parameter logic [CNT_W-1:0] RESET_COUNT = '0,
   parameter bit               SNAP_HI     = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            bus_sel,
   input  logic                            bus_wr,
   input  logic [frc_pkg::WIN_ADDR_W-1:0]  bus_addr,
   input  logic [BUS_W-1:0]                bus_wdata,
   output logic [BUS_W-1:0]                bus_rdata,
   output logic [CNT_W-1:0]                count_o,
   output logic                            step_o
);

   import frc_pkg::*;

   localparam int HI_W = CNT_W - BUS_W;

   frc_reg_e          reg_sel;
   logic              wr_incr;
   logic              wr_mod;
   logic              ratio_wr;
   logic              latch_hi;
   logic [BUS_W-1:0]  incr_word;
   logic [BUS_W-1:0]  mod_word;
   logic [FRAC_W-1:0] incr;
   logic [FRAC_W-1:0] modulus;
   logic              step;
   logic [CNT_W-1:0]  count;
   logic [HI_W-1:0]   hi_word;

   always_comb begin
      reg_sel  = frc_decode(bus_addr);
      wr_incr  = bus_sel && bus_wr && (reg_sel == REG_INCR);
      wr_mod   = bus_sel && bus_wr && (reg_sel == REG_MOD);
      ratio_wr = wr_incr || wr_mod;
      latch_hi = bus_sel && !bus_wr && (reg_sel == REG_CNT_LO);
   end

   frc_ratio_regs #(
      .BUS_W(BUS_W), .FRAC_W(FRAC_W), .RESET_NUM(RESET_NUM), .RESET_DEN(RESET_DEN)
   ) u_regs (
      .clk(clk), .rst(rst), .wr_incr(wr_incr), .wr_mod(wr_mod), .wdata(bus_wdata),
      .incr_word(incr_word), .mod_word(mod_word), .incr(incr), .modulus(modulus)
   );

   frc_accum #(.FRAC_W(FRAC_W)) u_acc (
      .clk(clk), .rst(rst), .clr(ratio_wr), .incr(incr), .modulus(modulus), .step(step)
   );

   frc_count #(
      .CNT_W(CNT_W), .BUS_W(BUS_W), .RESET_COUNT(RESET_COUNT), .SNAP_HI(SNAP_HI)
   ) u_cnt (
      .clk(clk), .rst(rst), .step(step), .latch_hi(latch_hi),
      .count(count), .hi_word(hi_word)
   );

   always_comb begin
      case (reg_sel)
         REG_CNT_LO: bus_rdata = count[BUS_W-1:0];
         REG_CNT_HI: bus_rdata = BUS_W'(hi_word);
         REG_INCR:   bus_rdata = incr_word;
         REG_MOD:    bus_rdata = mod_word;
         default:    bus_rdata = '0;
      endcase
   end

   assign count_o = count;
   assign step_o  = step;

   assert_step_moves_count_R2: assert property (@(posedge clk) disable iff (rst)
      step_o |=> (count_o == $past(count_o) + CNT_W'(1)))
      else $error("step pulse without increment");

   assert_ratio_write_freezes_R4: assert property (@(posedge clk) disable iff (rst)
      ratio_wr |=> (count_o == $past(count_o)))
      else $error("count moved on ratio write");

   assert_zero_ratio_holds_R5: assert property (@(posedge clk) disable iff (rst)
      (!ratio_wr && (incr == '0 || modulus == '0)) |=> $stable(count_o))
      else $error("count moved with zero ratio");

endmodule

// File: tb/sim_frc_master_counter.sv
module sim_frc_master_counter;

   localparam logic [63:0] RC = 64'h0000_0002_FFFF_FF80;

   typedef struct {
      logic [63:0] v;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] count_o;
   logic        step_o;

   int   vectors = 0;
   int   fails = 0;
   int   edges = 0;
   exp_t exp_q[$];

   always #5 clk = ~clk;

   frc_master_counter #(.RESET_COUNT(RC)) u0 (
      .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count_o(count_o), .step_o(step_o)
   );

   always @(posedge clk) begin
      if (rst) edges <= 0;
      else     edges <= edges + 1;
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: compares the count against the scoreboard queue
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         check(e.tag, count_o, e.v);
      end
   end

   task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   // driver: programs a ratio by read-modify-write and queues expected counts
   task automatic run_ratio(input logic [11:0] num, input logic [11:0] den,
                            input int cycles, input string tag);
      logic [31:0] wn, wd, rb;
      logic [63:0] c0, base;
      bus_read(5'h10, wn);
      bus_read(5'h14, wd);
      c0 = count_o;
      bus_write(5'h10, (wn & 32'hFFFF_F000) | 32'(num));
      bus_write(5'h14, (wd & 32'hFFFF_F000) | 32'(den));
      base = count_o;
      check({tag, " R4 count kept over ratio write"}, base, c0);
      for (int n = 1; n <= cycles; n++) begin
         exp_t e;
         @(posedge clk);
         e.v   = (num == 0 || den == 0) ? base : base + (64'(n) * 64'(num)) / 64'(den);
         e.tag = tag;
         exp_q.push_back(e);
      end
      @(negedge clk);
      #2;
      check({tag, " queue drained"}, 64'(exp_q.size()), 64'd0);
      bus_read(5'h10, rb);
      check("R6 increment word upper bits kept", 64'(rb), 64'((wn & 32'hFFFF_F000) | 32'(num)));
      bus_read(5'h14, rb);
      check("R6 modulus word upper bits kept", 64'(rb), 64'((wd & 32'hFFFF_F000) | 32'(den)));
   endtask

   initial begin
      #1500000;
      fails++;
      $display("FAIL R2 watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      logic [31:0] lo, hi, w;
      logic [63:0] snap;
      repeat (3) @(negedge clk);
      check("R1 count at reset", count_o, RC);
      bus_read(5'h10, w);
      check("R1 increment at reset", 64'(w), 64'd4);
      bus_read(5'h14, w);
      check("R1 modulus at reset", 64'(w), 64'd25);
      rst = 1'b0;

      while (edges != 25) @(negedge clk);
      check("R9 four counts in 25 clocks", count_o, RC + 64'd4);
      while (edges != 50) @(negedge clk);
      check("R9 eight counts in 50 clocks", count_o, RC + 64'd8);

      while (edges != 100) @(negedge clk);
      snap = count_o;
      bus_read(5'h00, lo);
      bus_read(5'h04, hi);
      check("R7 paired read mid-word", {hi, lo}, snap);

      // low-word read in the cycle just before the low word rolls over
      while (edges != 799) @(negedge clk);
      snap = count_o;
      check("R2 count before roll", snap, RC + 64'd127);
      bus_read(5'h00, lo);
      bus_read(5'h04, hi);
      check("R7 paired read across roll", {hi, lo}, snap);
      @(negedge clk);
      bus_read(5'h04, hi);
      check("R7 upper word held until next low read", 64'(hi), 64'd2);
      bus_read(5'h00, lo);
      bus_read(5'h04, hi);
      check("R7 new capture after roll", 64'(hi), 64'd3);

      // R8: ignored writes and unmapped reads
      bus_read(5'h08, w);
      check("R8 unmapped read 0x08", 64'(w), 64'd0);
      bus_read(5'h1C, w);
      check("R8 unmapped read 0x1C", 64'(w), 64'd0);
      bus_write(5'h00, 32'h0);
      bus_write(5'h04, 32'h0);
      bus_write(5'h08, 32'hFFFF_FFFF);
      bus_write(5'h18, 32'hFFFF_FFFF);
      check("R8 count unaffected by ignored writes", count_o,
            RC + (64'(edges) * 64'd4) / 64'd25);
      bus_read(5'h10, w);
      check("R8 increment unaffected", 64'(w), 64'd4);
      bus_read(5'h14, w);
      check("R8 modulus unaffected", 64'(w), 64'd25);

      // R6: upper bits stored, no effect on rate
      bus_write(5'h10, 32'hABCD_E004);
      bus_read(5'h10, w);
      check("R6 increment word readback", 64'(w), 64'hABCD_E004);
      bus_write(5'h14, 32'h1234_5019);
      bus_read(5'h14, w);
      check("R6 modulus word readback", 64'(w), 64'h1234_5019);

      run_ratio(12'd64,  12'd125,  250,  "R2 ratio 64/125");
      run_ratio(12'd768, 12'd1625, 1625, "R2 ratio 768/1625");
      run_ratio(12'd8,   12'd25,   75,   "R2 ratio 8/25");
      run_ratio(12'd192, 12'd625,  625,  "R2 ratio 192/625");
      run_ratio(12'd384, 12'd1625, 1625, "R2 ratio 384/1625");
      run_ratio(12'd256, 12'd1125, 1125, "R2 ratio 256/1125");
      run_ratio(12'd25,  12'd25,   40,   "R3 ratio 25/25");
      run_ratio(12'd0,   12'd25,   100,  "R5 zero increment");
      run_ratio(12'd4,   12'd0,    100,  "R5 zero modulus");
      run_ratio(12'd75,  12'd244,  976,  "R9 ratio 75/244");
      run_ratio(12'd4,   12'd25,   100,  "R9 ratio 4/25");

      rst = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 count after second reset", count_o, RC);
      bus_read(5'h10, w);
      check("R1 increment word after second reset", 64'(w), 64'h0000_0004);
      bus_read(5'h14, w);
      check("R1 modulus word after second reset", 64'(w), 64'h0000_0019);
      rst = 1'b0;

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule